// File: doc/BRIEF.md
# Breakpoint and Watchpoint Compare Unit

This unit watches a processor core's instruction fetch and load/store traffic and requests a debug halt when a programmed condition is met. It holds a set of register pairs. Each pair has a 32-bit value word and a 32-bit control word. The control word chooses which quantity the pair watches, which relational test it applies and whether that test is signed. Because one comparator per pair serves every quantity, the same pair can act as a code breakpoint or as a data watchpoint.

A debugger programs the pairs through a single-cycle register write port. On every cycle, each present pair compares the selected quantity against its value word. The per-pair results, the index of the lowest-numbered pair that matched and a halt request are all registered. They appear on the outputs one cycle after the compare.

Top module: `bpu_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `hit_vec`, `hit_idx` and `halt_req` are 0. Reset clears every control word, so no pair matches until it is programmed.
- R2: A write with `cfg_we` high stores `cfg_wdata` into pair `cfg_addr[3:1]`. `cfg_addr[0]`=0 selects the value word and 1 selects the control word. The compare made in the cycle of the write still uses the old contents. The new contents take effect from the next cycle.
- R3: Control bit 0 marks a pair present. A pair with this bit clear never matches.
- R4: Control bits 3:1 choose the test of the selected quantity Q against the value word V. The codes are 001 Q==V, 010 Q<V, 011 Q<=V, 100 Q>V, 101 Q>=V and 110 Q!=V. Codes 000 and 111 never match.
- R5: Control bit 4 set makes the test use two's-complement signed operands. Clear makes it unsigned.
- R6: Control bits 7:5 choose Q. The codes are 001 fetch address, 010 load address, 011 store address, 100 load data, 101 store data, 110 load-or-store address and 111 load-or-store data. Code 000 disables the pair.
- R7: A compare only counts when the strobe of its quantity is high in that cycle (`if_valid`, `ld_valid` or `st_valid`). For codes 110 and 111 either strobe qualifies, and the load side is used when `ld_valid` is high.
- R8: Control bits 31:8 have no effect on matching.
- R9: `hit_vec[i]` is high in the cycle after pair i matched.
- R10: `hit_idx` is the lowest i with `hit_vec[i]` set, and 0 when `hit_vec` is 0.
- R11: `halt_req` is high exactly when `hit_vec` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Pair index in bits 3:1, word select in bit 0 |
| cfg_wdata | input | 32 | Write data |
| if_valid | input | 1 | Fetch address valid |
| if_addr | input | 32 | Instruction fetch address |
| ld_valid | input | 1 | Load valid |
| ld_addr | input | 32 | Load effective address |
| ld_data | input | 32 | Load data |
| st_valid | input | 1 | Store valid |
| st_addr | input | 32 | Store effective address |
| st_data | input | 32 | Store data |
| hit_vec | output | 8 | Registered per-pair match flags |
| hit_idx | output | 3 | Lowest matching pair index |
| halt_req | output | 1 | Debug halt request |

## Verification
A register write and a compare can fall in the same cycle. The bench programs a pair's control word while presenting traffic that the new setting would match. It expects no hit in that cycle and a hit on the following identical cycle. Several pairs matching in the same cycle is the second overlap. The bench matches a fetch pair and a load pair together and judges the full hit vector and the lowest index.

// File: rtl/bpu_pkg.sv
package bpu_pkg;
    typedef enum logic [2:0] {
        COND_NEVER = 3'b000, COND_EQ = 3'b001, COND_LT = 3'b010, COND_LE = 3'b011,
        COND_GT = 3'b100, COND_GE = 3'b101, COND_NE = 3'b110, COND_RSV = 3'b111
    } cond_e;

    typedef enum logic [2:0] {
        SRC_OFF = 3'b000, SRC_FADDR = 3'b001, SRC_LADDR = 3'b010, SRC_SADDR = 3'b011,
        SRC_LDATA = 3'b100, SRC_SDATA = 3'b101, SRC_LSADDR = 3'b110, SRC_LSDATA = 3'b111
    } src_e;

    typedef struct packed {
        logic [23:0] spare;
        src_e        src;
        logic        sgn;
        cond_e       cond;
        logic        present;
    } ctl_t;
endpackage

// File: rtl/bpu_regs.sv
module bpu_regs #(
    parameter int NPAIR = 8,
    parameter int DW    = 32,
    localparam int IW   = $clog2(NPAIR),
    localparam int AW   = IW + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [AW-1:0]              addr,
    input  logic [DW-1:0]              wdata,
    output logic [NPAIR-1:0][DW-1:0]   val_o,
    output logic [NPAIR-1:0][DW-1:0]   ctl_o
);
    typedef struct packed {
        logic [NPAIR-1:0][DW-1:0] val;
        logic [NPAIR-1:0][DW-1:0] ctl;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            if (addr[0]) st_d.ctl[addr[AW-1:1]] = wdata;
            else         st_d.val[addr[AW-1:1]] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign val_o = st_q.val;
    assign ctl_o = st_q.ctl;
endmodule

// File: rtl/bpu_cmp.sv
module bpu_cmp
    import bpu_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [31:0]   ctl,
    input  logic [DW-1:0] val,
    input  logic          if_valid,
    input  logic [DW-1:0] if_addr,
    input  logic          ld_valid,
    input  logic [DW-1:0] ld_addr,
    input  logic [DW-1:0] ld_data,
    input  logic          st_valid,
    input  logic [DW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    output logic          hit
);
    ctl_t          c;
    logic [DW-1:0] q;
    logic          qv;
    logic          lt, eq;

    assign c = ctl_t'(ctl);

    always_comb begin
        q  = '0;
        qv = 1'b0;
        unique case (c.src)
            SRC_FADDR:  begin q = if_addr; qv = if_valid; end
            SRC_LADDR:  begin q = ld_addr; qv = ld_valid; end
            SRC_SADDR:  begin q = st_addr; qv = st_valid; end
            SRC_LDATA:  begin q = ld_data; qv = ld_valid; end
            SRC_SDATA:  begin q = st_data; qv = st_valid; end
            SRC_LSADDR: begin q = ld_valid ? ld_addr : st_addr; qv = ld_valid | st_valid; end
            SRC_LSDATA: begin q = ld_valid ? ld_data : st_data; qv = ld_valid | st_valid; end
            default:    begin q = '0; qv = 1'b0; end
        endcase
    end

    assign eq = (q == val);
    assign lt = c.sgn ? ($signed(q) < $signed(val)) : (q < val);

    always_comb begin
        logic rel;
        unique case (c.cond)
            COND_EQ: rel = eq;
            COND_LT: rel = lt;
            COND_LE: rel = lt | eq;
            COND_GT: rel = ~(lt | eq);
            COND_GE: rel = ~lt;
            COND_NE: rel = ~eq;
            default: rel = 1'b0;
        endcase
        hit = c.present & qv & rel;
    end
endmodule

// File: rtl/bpu_prio.sv
module bpu_prio #(
    parameter int N  = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic [IW-1:0] idx
);
    always_comb begin
        logic found;
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                idx   = IW'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/bpu_top.sv
module bpu_top #(
    parameter int NPAIR = 8,
    parameter int DW    = 32,
    localparam int IW   = $clog2(NPAIR),
    localparam int AW   = IW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [DW-1:0]    cfg_wdata,
    input  logic             if_valid,
    input  logic [DW-1:0]    if_addr,
    input  logic             ld_valid,
    input  logic [DW-1:0]    ld_addr,
    input  logic [DW-1:0]    ld_data,
    input  logic             st_valid,
    input  logic [DW-1:0]    st_addr,
    input  logic [DW-1:0]    st_data,
    output logic [NPAIR-1:0] hit_vec,
    output logic [IW-1:0]    hit_idx,
    output logic             halt_req
);
    logic [NPAIR-1:0][DW-1:0] val;
    logic [NPAIR-1:0][DW-1:0] ctl;
    logic [NPAIR-1:0]         hits;
    logic [IW-1:0]            first;

    bpu_regs #(.NPAIR(NPAIR), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .val_o(val), .ctl_o(ctl)
    );

    for (genvar g = 0; g < NPAIR; g++) begin : g_pair
        bpu_cmp #(.DW(DW)) u_cmp (
            .ctl(ctl[g][31:0]), .val(val[g]),
            .if_valid(if_valid), .if_addr(if_addr),
            .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_data(ld_data),
            .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
            .hit(hits[g])
        );
    end

    bpu_prio #(.N(NPAIR)) u_prio (.req(hits), .idx(first));

    typedef struct packed {
        logic [NPAIR-1:0] vec;
        logic [IW-1:0]    idx;
        logic             halt;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d.vec  = hits;
        out_d.idx  = first;
        out_d.halt = |hits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign hit_vec  = out_q.vec;
    assign hit_idx  = out_q.idx;
    assign halt_req = out_q.halt;
endmodule

// File: rtl/bpu_chk.sv
module bpu_chk #(
    parameter int NPAIR = 8,
    localparam int IW   = $clog2(NPAIR)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             if_valid,
    input logic             ld_valid,
    input logic             st_valid,
    input logic [NPAIR-1:0] hit_vec,
    input logic [IW-1:0]    hit_idx,
    input logic             halt_req
);
    assert_halt_iff_hit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req == (hit_vec != '0));

    assert_idx_is_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vec != '0) |-> hit_vec[hit_idx]);

    assert_idx_is_lowest_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vec & ((NPAIR'(1) << hit_idx) - NPAIR'(1))) == '0);

    assert_idx_zero_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vec == '0) |-> (hit_idx == '0));

    assert_no_strobe_no_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!if_valid && !ld_valid && !st_valid) |=> (hit_vec == '0));
endmodule

bind bpu_top bpu_chk #(.NPAIR(NPAIR)) u_chk (
    .clk(clk), .rst_n(rst_n), .if_valid(if_valid), .ld_valid(ld_valid),
    .st_valid(st_valid), .hit_vec(hit_vec), .hit_idx(hit_idx), .halt_req(halt_req)
);

// File: tb/tb_bpu_top.sv
module tb_bpu_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        if_valid = 1'b0, ld_valid = 1'b0, st_valid = 1'b0;
    logic [31:0] if_addr = '0, ld_addr = '0, ld_data = '0, st_addr = '0, st_data = '0;
    logic [7:0]  hit_vec;
    logic [2:0]  hit_idx;
    logic        halt_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] mval [8];
    logic [31:0] mctl [8];

    typedef struct {
        logic [7:0] vec;
        logic [2:0] idx;
        logic       halt;
        string      tag;
    } exp_t;
    exp_t sbq [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    bpu_top dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .if_valid(if_valid), .if_addr(if_addr),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_data(ld_data),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
        .hit_vec(hit_vec), .hit_idx(hit_idx), .halt_req(halt_req)
    );

    function automatic bit rel(logic [31:0] q, logic [31:0] v, logic [2:0] cc, bit sg);
        bit l, e;
        e = (q == v);
        l = sg ? ($signed(q) < $signed(v)) : (q < v);
        case (cc)
            3'd1: return e;
            3'd2: return l;
            3'd3: return l || e;
            3'd4: return !(l || e);
            3'd5: return !l;
            3'd6: return !e;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit model_hit(int i);
        logic [31:0] c, q;
        bit qv;
        c = mctl[i];
        if (!c[0]) return 1'b0;
        case (c[7:5])
            3'd1: begin q = if_addr; qv = if_valid; end
            3'd2: begin q = ld_addr; qv = ld_valid; end
            3'd3: begin q = st_addr; qv = st_valid; end
            3'd4: begin q = ld_data; qv = ld_valid; end
            3'd5: begin q = st_data; qv = st_valid; end
            3'd6: begin q = ld_valid ? ld_addr : st_addr; qv = ld_valid || st_valid; end
            3'd7: begin q = ld_valid ? ld_data : st_data; qv = ld_valid || st_valid; end
            default: begin q = '0; qv = 1'b0; end
        endcase
        return qv && rel(q, mval[i], c[3:1], c[4]);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: push expectation for the inputs now applied, then advance one cycle
    task automatic step(string tag);
        exp_t e;
        e.vec = '0;
        for (int i = 0; i < 8; i++) e.vec[i] = model_hit(i);
        e.idx = '0;
        for (int i = 7; i >= 0; i--) if (e.vec[i]) e.idx = 3'(i);
        e.halt = |e.vec;
        e.tag = tag;
        sbq.push_back(e);
        if (cfg_we) begin
            if (cfg_addr[0]) mctl[cfg_addr[3:1]] = cfg_wdata;
            else             mval[cfg_addr[3:1]] = cfg_wdata;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        cfg_we = 0; if_valid = 0; ld_valid = 0; st_valid = 0;
    endtask

    task automatic wr(int pair, bit is_ctl, logic [31:0] d);
        idle();
        cfg_we = 1; cfg_addr = {3'(pair), is_ctl}; cfg_wdata = d;
        step("R2 write");
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                check({e.tag, " R9 hit_vec"}, 32'(hit_vec), 32'(e.vec));
                check({e.tag, " R10 hit_idx"}, 32'(hit_idx), 32'(e.idx));
                check({e.tag, " R11 halt_req"}, 32'(halt_req), 32'(e.halt));
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin mval[i] = '0; mctl[i] = '0; end
        repeat (3) @(negedge clk);
        check("R1 reset hit_vec", 32'(hit_vec), 0);
        check("R1 reset halt_req", 32'(halt_req), 0);
        rst_n = 1;
        // R1: cleared controls match nothing even for zero operands
        idle(); if_valid = 1; ld_valid = 1; st_valid = 1; step("R1 cleared");

        // R2: write control in same cycle as matching fetch
        wr(0, 0, 32'h0000_1000);
        idle(); cfg_we = 1; cfg_addr = 4'b0001; cfg_wdata = 32'h23;
        if_valid = 1; if_addr = 32'h1000; step("R2 same-cycle");
        idle(); if_valid = 1; if_addr = 32'h1000; step("R2 next R6 fetch");

        // R10: pair0 fetch and pair3 load-address less-than match together
        wr(3, 0, 32'h0000_8000);
        wr(3, 1, 32'h45);
        idle(); if_valid = 1; if_addr = 32'h1000; ld_valid = 1; ld_addr = 32'h7fff;
        step("R10 two hits");
        idle(); ld_valid = 1; ld_addr = 32'h8000; step("R4 lt boundary");

        // R5: signed vs unsigned greater-than on load data
        wr(5, 0, 32'hFFFF_FFF0);
        wr(5, 1, 32'h99);
        idle(); ld_valid = 1; ld_data = 32'h0; ld_addr = 32'h0; step("R5 signed");
        wr(5, 1, 32'h89);
        idle(); ld_valid = 1; ld_data = 32'h0; step("R5 unsigned");

        // R3: present bit cleared
        wr(5, 1, 32'h98);
        idle(); ld_valid = 1; ld_data = 32'h0; step("R3 absent");

        // R8: reserved bits set
        wr(1, 0, 32'h0000_2000);
        wr(1, 1, 32'hABCD_EF23);
        idle(); if_valid = 1; if_addr = 32'h2000; step("R8 reserved");

        // R7: strobe low, matching value
        idle(); if_valid = 0; if_addr = 32'h2000; step("R7 no strobe");

        // R7/R6: combined address code
        wr(2, 0, 32'h40);
        wr(2, 1, 32'hC3);
        idle(); ld_valid = 1; ld_addr = 32'h40; st_addr = 32'h0; step("R7 ls load");
        idle(); ld_valid = 1; ld_addr = 32'h0; st_valid = 1; st_addr = 32'h40; step("R7 ls both");
        idle(); st_valid = 1; st_addr = 32'h40; step("R7 ls store");
        // R6: disabled source code
        wr(2, 1, 32'h03);
        idle(); ld_valid = 1; st_valid = 1; ld_addr = 32'h40; st_addr = 32'h40; step("R6 off");

        // R4/R5: every condition on store data
        wr(6, 0, 32'h0000_0100);
        for (int cc = 0; cc < 8; cc++) begin
            for (int sg = 0; sg < 2; sg++) begin
                wr(6, 1, 32'hA1 | (32'(cc) << 1) | (32'(sg) << 4));
                for (int d = -1; d <= 1; d++) begin
                    idle(); st_valid = 1; st_data = 32'h100 + 32'(d); step("R4 cond sweep");
                end
                idle(); st_valid = 1; st_data = 32'hFFFF_FF00; step("R5 cond sweep sign");
            end
        end

        idle(); step("drain");
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule